// File: doc/BRIEF.md
# Cascade-Serial FIR Filter Engine

This block computes a finite impulse response filter one output per input sample. It shares a few multipliers across all taps. The taps are split into groups, and each group has its own lane. A lane holds a selector that picks one tap's sample and coefficient per cycle, and one multiply-accumulate stage. All lanes run at the same time, and each lane walks through its own taps one by one.

The lanes are chained. After a lane has finished its own products, it adds the finished total of the lane after it in a single extra step. Lane 0 therefore ends up holding the complete sum, and no adder tree is needed after the lanes. This chaining only works if every lane has one tap more than the lane that follows it. The lane sizes are built that way: lane p has `FIRST_TAPS - p` taps.

A computation takes `FIRST_TAPS + 1` clock cycles. The clock is meant to run at that multiple of the sample rate. Coefficients are fixed at build time through a packed parameter.

Top module: `cfir_cascade`

## Requirements
- R1: While reset is asserted and directly after it, `outValid` is 0 and `outData` is 0. The tap history starts as all zeros.
- R2: Coefficient i sits at bits [i*COEF_W +: COEF_W] of `COEF_ROM` and weights the sample accepted i samples before the newest one. A single 1 followed by zeros therefore produces the coefficients in index order, c0 first.
- R3: Each output equals the signed sum over i of c[i] times x[n-i], where x[n] is the newest accepted sample. Older history is taken as zero.
- R4: `outValid` is a one-cycle pulse. It is high in the cycle after the (FIRST_TAPS+1)-th rising edge that follows the edge that accepted the sample, which is 5 edges with the default parameters.
- R5: A sample offered exactly FIRST_TAPS+1 cycles after the previous one is accepted, so samples can be sent back to back at the full rate. Each sample then gets its own correct output.
- R6: An `inValid` pulse that arrives while a computation is running, at any step other than its last one, is ignored. It does not shift the history and does not produce an extra `outValid`.
- R7: The accumulator width DATA_W+COEF_W+clog2(taps) holds the full range of the result. The extreme inputs -128 and 127 give exact results with no wrap.
- R8: Between computations, `outData` holds the last result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | ACC_W | Signed filter result |

## Verification
A lane that selects the wrong tap or the wrong coefficient is caught by the impulse test. The bad value shows up in the very first output whose index meets that tap. A chaining step that fires at the wrong moment adds a stale or partial total from the next lane, so every output that depends on taps 4..8 goes wrong. An accept condition that is too loose shifts the history when it should not. That error shows up in the next result, one computation later.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  localparam int STEP_W = 8;

  typedef struct packed {
    logic              shift;
    logic              run;
    logic [STEP_W-1:0] step;
  } cfir_ctrl_t;

  function automatic int laneTaps(input int firstTaps, input int lane);
    return firstTaps - lane;
  endfunction

  function automatic int laneOffset(input int firstTaps, input int lane);
    return lane * firstTaps - (lane * (lane - 1)) / 2;
  endfunction

endpackage

// File: rtl/cfir_ctrl.sv
module cfir_ctrl
  import cfir_pkg::*;
#(
  parameter int FIRST_TAPS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output cfir_ctrl_t ctrl,
  output logic       outValid
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FIRST_TAPS);

  logic              busy;
  logic [STEP_W-1:0] step;
  logic              accept;

  assign accept = inValid && (!busy || step == LAST_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      step     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= busy && (step == LAST_STEP);
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (step == LAST_STEP) begin
          busy <= 1'b0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.shift = accept;
    ctrl.run   = busy;
    ctrl.step  = step;
  end

  // R4: the result strobe never stays high for two cycles in a row
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R5: the step counter never runs past the chaining step
  assert_step_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> step <= LAST_STEP);

endmodule

// File: rtl/cfir_lane.sv
module cfir_lane
  import cfir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 20,
  parameter int NUM_TAPS = 9,
  parameter int TAPS     = 4,
  parameter int OFFSET   = 0,
  parameter bit HAS_NEXT = 1'b1,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_ROM = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfir_ctrl_t                 ctrl,
  input  logic [NUM_TAPS*DATA_W-1:0] line,
  input  logic signed [ACC_W-1:0]    nextAcc,
  output logic signed [ACC_W-1:0]    acc
);

  localparam logic [STEP_W-1:0] MAC_END = STEP_W'(TAPS);

  logic signed [DATA_W-1:0]        sampleSel;
  logic signed [COEF_W-1:0]        coefSel;
  logic signed [DATA_W+COEF_W-1:0] prod;
  logic signed [ACC_W-1:0]         prodExt;

  always_comb begin
    sampleSel = '0;
    coefSel   = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (ctrl.step == STEP_W'(k)) begin
        sampleSel = $signed(line[(OFFSET + k)*DATA_W +: DATA_W]);
        coefSel   = $signed(COEF_ROM[(OFFSET + k)*COEF_W +: COEF_W]);
      end
    end
  end

  assign prod    = sampleSel * coefSel;
  assign prodExt = ACC_W'(prod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (ctrl.run) begin
      if (ctrl.step < MAC_END) begin
        acc <= ((ctrl.step == '0) ? '0 : acc) + prodExt;
      end else if (HAS_NEXT && ctrl.step == MAC_END) begin
        acc <= acc + nextAcc;
      end
    end
  end

  // R8: the accumulator stays put while no computation runs
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> $stable(acc));

endmodule

// File: rtl/cfir_datapath.sv
module cfir_datapath
  import cfir_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int COEF_W     = 8,
  parameter int ACC_W      = 20,
  parameter int NUM_PART   = 3,
  parameter int FIRST_TAPS = 4,
  parameter int NUM_TAPS   = 9,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_ROM = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfir_ctrl_t              ctrl,
  input  logic [DATA_W-1:0]       inData,
  output logic signed [ACC_W-1:0] outData
);

  logic [NUM_TAPS*DATA_W-1:0] line;
  logic signed [ACC_W-1:0]    laneAcc [NUM_PART+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      line <= '0;
    end else if (ctrl.shift) begin
      line <= {line[(NUM_TAPS-1)*DATA_W-1:0], inData};
    end
  end

  assign laneAcc[NUM_PART] = '0;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_lane
    cfir_lane #(
      .DATA_W  (DATA_W),
      .COEF_W  (COEF_W),
      .ACC_W   (ACC_W),
      .NUM_TAPS(NUM_TAPS),
      .TAPS    (laneTaps(FIRST_TAPS, p)),
      .OFFSET  (laneOffset(FIRST_TAPS, p)),
      .HAS_NEXT(p < NUM_PART - 1),
      .COEF_ROM(COEF_ROM)
    ) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .ctrl   (ctrl),
      .line   (line),
      .nextAcc(laneAcc[p+1]),
      .acc    (laneAcc[p])
    );
  end

  assign outData = laneAcc[0];

  // R3: an accepted sample enters the newest history slot
  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shift |=> line[DATA_W-1:0] == $past(inData));

endmodule

// File: rtl/cfir_cascade.sv
module cfir_cascade
  import cfir_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int COEF_W     = 8,
  parameter int NUM_PART   = 3,
  parameter int FIRST_TAPS = 4,
  parameter int NUM_TAPS   = NUM_PART*FIRST_TAPS - (NUM_PART*(NUM_PART-1))/2,
  parameter int ACC_W      = DATA_W + COEF_W + $clog2(NUM_TAPS),
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_ROM = 72'h05_FA_02_09_FB_01_04_FF_03
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       inData,
  output logic                    outValid,
  output logic signed [ACC_W-1:0] outData
);

  cfir_ctrl_t ctrl;

  initial begin
    assert_lane_sizes_R5: assert (FIRST_TAPS >= NUM_PART && FIRST_TAPS < 255);
  end

  cfir_ctrl #(
    .FIRST_TAPS(FIRST_TAPS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  cfir_datapath #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .ACC_W     (ACC_W),
    .NUM_PART  (NUM_PART),
    .FIRST_TAPS(FIRST_TAPS),
    .NUM_TAPS  (NUM_TAPS),
    .COEF_ROM  (COEF_ROM)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .inData (inData),
    .outData(outData)
  );

  // R1: no result strobe in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

endmodule

// File: tb/cfir_cascade_bench.sv
module cfir_cascade_bench;

  localparam int LAT   = 5;
  localparam int NTAPS = 9;
  localparam int ACC_W = 20;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    inValid = 1'b0;
  logic [7:0]              inData = '0;
  logic                    outValid;
  logic signed [ACC_W-1:0] outData;

  int checks = 0;
  int errors = 0;
  int cf [NTAPS] = '{3, -1, 4, 1, -5, 9, 2, -6, 5};
  int hist [NTAPS];
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfir_cascade u_cfir_cascade (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modelPush(input int v);
    int s = 0;
    for (int i = NTAPS-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    for (int i = 0; i < NTAPS; i++) s += cf[i] * hist[i];
    return s;
  endfunction

  task automatic sendOne(input int v, input string req);
    int exp;
    int cnt = 0;
    exp = modelPush(v);
    @(negedge clk);
    inValid = 1'b1;
    inData  = 8'(v);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    #1;
    while (!outValid && cnt < 20) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    if (cnt == 0) cnt = 99;
    check({req, " latency"}, cnt, LAT);
    check({req, " data"}, outData, exp);
  endtask

  task automatic testReset();
    #1;
    check("R1 outValid in reset", outValid, 0);
    check("R1 outData in reset", outData, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 outValid after reset", outValid, 0);
    check("R1 outData after reset", outData, 0);
  endtask

  task automatic testImpulse();
    sendOne(1, "R2 impulse c0");
    for (int i = 1; i < NTAPS; i++) sendOne(0, "R2 impulse tail");
    sendOne(0, "R2 impulse flush");
  endtask

  task automatic testPattern();
    int pat [8] = '{17, -42, 99, 3, -7, 120, -128, 55};
    foreach (pat[i]) sendOne(pat[i], "R3 convolution");
  endtask

  task automatic testExtremes();
    for (int i = 0; i < NTAPS; i++) sendOne(-128, "R7 all min");
    for (int i = 0; i < NTAPS; i++) sendOne((i % 2) ? 127 : -128, "R7 alternating");
  endtask

  task automatic testBackToBack();
    int vals [6] = '{10, -20, 30, -40, 50, -60};
    int exps [6];
    foreach (vals[k]) begin
      exps[k] = modelPush(vals[k]);
      @(negedge clk);
      inValid = 1'b1;
      inData  = 8'(vals[k]);
      @(posedge clk);
      #1;
      if (k > 0) begin
        check("R5 back-to-back strobe", outValid, 1);
        check("R5 back-to-back data", outData, exps[k-1]);
      end
      @(negedge clk);
      inValid = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (2) @(posedge clk);
    #1;
    check("R5 last strobe", outValid, 1);
    check("R5 last data", outData, exps[5]);
  endtask

  task automatic testIgnore();
    int exp;
    int pulses = 0;
    exp = modelPush(77);
    @(negedge clk);
    inValid = 1'b1;
    inData  = 8'd77;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    inValid = 1'b1;
    inData  = 8'd100;
    @(negedge clk);
    inValid = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk);
      #1;
      if (outValid) begin
        pulses++;
        check("R6 data unaffected", outData, exp);
      end
    end
    check("R6 single pulse", pulses, 1);
    sendOne(-5, "R6 history not shifted");
  endtask

  task automatic testHold();
    logic signed [ACC_W-1:0] held;
    held = outData;
    repeat (20) @(posedge clk);
    #1;
    check("R8 output holds", outData, held);
    check("R8 no strobe idle", outValid, 0);
  endtask

  initial begin
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    testReset();
    testImpulse();
    testPattern();
    testExtremes();
    testBackToBack();
    testIgnore();
    testHold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule